// File: doc/BRIEF.md
# Vertical Clock Pattern Group Selector

This block drives a bank of vertical shift clock lines for one image-sensor readout line. A line begins on the rising edge of a horizontal sync input. A pixel counter then steps once per clock, and each output inverts whenever the counter reaches one of its toggle positions. The toggle positions and the start level of each output come from a bank of stored pattern groups. Every group holds, for each output, one start level and four toggle slots.

Four group pointers (A to D) each name one stored group. A 2-bit select field per output ties that output to one pointer, so most outputs can follow one group while a few run special timing from another. In chained mode the toggle slots of the groups named by A, B, C and D are merged into a single list of up to sixteen edges for every output.

Pointer, select and chained-mode writes wait in a shadow copy and take effect at the next line start, so a line never changes pattern partway through. Pattern-bank writes take effect immediately.

Top module: `vcp_group_sel`

## Requirements
- R1: After reset every output is low, all select fields, pointers and the chained-mode bit are zero, every toggle slot holds all-ones and every start level is zero. No output moves until the first line start.
- R2: A line start is the clock edge L at which hsync is sampled high after being sampled low. At L each output loads its start level. A toggle position p inverts the output at edge L+p+1, which is when the counter first shows p+1.
- R3: The select field of each output picks a pointer with the encoding 0 = A, 1 = B, 2 = C, 3 = D. Each output uses its own field, independently of the other outputs.
- R4: A pointer holds a 4-bit group number, 0 to 15. An output takes its toggle slots and its start level from the group named by its selected pointer.
- R5: A group gives each output four toggle slots. A slot holding all-ones (8191) never matches. Several slots with the same value invert the output only once.
- R6: With chained mode set, each output's toggle list is the four slots of the group named by A, then those of B, C and D, for sixteen slots. The start level comes from the group named by A.
- R7: In chained mode, when B, C and D name the same group, the repeated slots collapse and the output shows at most eight edges.
- R8: Writes to pointers, select fields and the chained-mode bit change nothing in the line in progress. They apply at the next line start. Pattern-bank writes apply at once.
- R9: The counter stops at all-ones. Holding hsync high gives only one line start.
- R10: Write address map (13 bits, one write per cycle when wr_en is high).
  - Bit 12 = 0 addresses the pattern bank: group in bits 11:8, output in bits 7:3, slot in bits 2:0. Slots 0 to 3 take a toggle position from data bits 12:0. Slot 4 takes the start level from data bit 0.
  - Bit 12 = 1 addresses the configuration: kind in bits 7:5, index in bits 4:0. Kind 0 writes pointer index[1:0] from data bits 3:0. Kind 1 writes the select field of output index from data bits 1:0. Kind 2 writes the chained-mode bit from data bit 0.
  - Slots 5 to 7, output numbers 24 to 31 and other kinds are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_addr | input | 13 | Write address (see R10) |
| wr_data | input | 13 | Write data |
| vout | output | 24 | Vertical clock outputs |

## Verification
A wrong pointer, select or chained-mode value shows at the ports as soon as the first toggle position of the affected output is reached. A wrong start level already shows in the cycle after the line start. A counter that is off by one shifts every edge of every output by one cycle, so comparing each output in every cycle of a line catches it at the first edge. A shadow copy that takes effect too early changes the line in progress, and the cycle-by-cycle comparison shows this at the next edge that differs between the old and new patterns.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  // Kinds of configuration write, decoded from the address
  typedef enum logic [2:0] {
    CFG_PTR = 3'd0,
    CFG_SEL = 3'd1,
    CFG_CAT = 3'd2
  } cfg_kind_e;

  // Number of group pointers; fixed by the 2-bit select encoding
  localparam int unsigned VCP_N_PTR = 4;
endpackage

// File: rtl/vcp_line_timer.sv
module vcp_line_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  output logic             line_start,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_PARK = '1;

  logic hsync_q;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return (c == CNT_PARK) ? CNT_PARK : c + 1'b1;
  endfunction

  assign line_start = hsync & ~hsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_q <= 1'b0;
      cnt     <= CNT_PARK;
    end else begin
      hsync_q <= hsync;
      cnt     <= line_start ? '0 : cnt_next(cnt);
    end
  end
endmodule

// File: rtl/vcp_regbank.sv
module vcp_regbank
  import vcp_pkg::*;
#(
  parameter int unsigned N_OUT = 24,
  parameter int unsigned N_GRP = 16,
  parameter int unsigned CNT_W = 13,
  parameter int unsigned N_TOG = 4,
  localparam int unsigned GRP_W  = $clog2(N_GRP),
  localparam int unsigned OUT_W  = $clog2(N_OUT),
  localparam int unsigned TOG_W  = $clog2(N_TOG),
  localparam int unsigned SLOT_W = $clog2(N_TOG + 1),
  localparam int unsigned ADDR_W = 1 + GRP_W + OUT_W + SLOT_W,
  localparam int unsigned PSEL_W = $clog2(VCP_N_PTR)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic line_start,
  output logic [N_GRP-1:0][N_OUT-1:0][N_TOG-1:0][CNT_W-1:0] tog_mem,
  output logic [N_GRP-1:0][N_OUT-1:0] pol_mem,
  output logic [VCP_N_PTR-1:0][GRP_W-1:0] ptr_act,
  output logic [VCP_N_PTR-1:0][GRP_W-1:0] ptr_shd,
  output logic [N_OUT-1:0][PSEL_W-1:0] sel_act,
  output logic [N_OUT-1:0][PSEL_W-1:0] sel_shd,
  output logic cat_act,
  output logic cat_shd
);
  logic              is_cfg;
  logic [GRP_W-1:0]  w_grp;
  logic [OUT_W-1:0]  w_out;
  logic [SLOT_W-1:0] w_slot;
  cfg_kind_e         w_kind;
  logic [OUT_W-1:0]  w_idx;

  assign is_cfg = wr_addr[ADDR_W-1];
  assign w_grp  = wr_addr[ADDR_W-2 -: GRP_W];
  assign w_out  = wr_addr[SLOT_W +: OUT_W];
  assign w_slot = wr_addr[SLOT_W-1:0];
  assign w_kind = cfg_kind_e'(wr_addr[OUT_W +: 3]);
  assign w_idx  = wr_addr[OUT_W-1:0];

  // Pattern bank: applied at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_mem <= '1;
      pol_mem <= '0;
    end else if (wr_en && !is_cfg && (int'(w_out) < N_OUT)) begin
      if (w_slot < SLOT_W'(N_TOG))
        tog_mem[w_grp][w_out][w_slot[TOG_W-1:0]] <= wr_data;
      else if (w_slot == SLOT_W'(N_TOG))
        pol_mem[w_grp][w_out] <= wr_data[0];
    end
  end

  // Configuration shadow: written any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_shd <= '0;
      sel_shd <= '0;
      cat_shd <= 1'b0;
    end else if (wr_en && is_cfg) begin
      case (w_kind)
        CFG_PTR: ptr_shd[w_idx[PSEL_W-1:0]] <= wr_data[GRP_W-1:0];
        CFG_SEL: if (int'(w_idx) < N_OUT) sel_shd[w_idx] <= wr_data[PSEL_W-1:0];
        CFG_CAT: cat_shd <= wr_data[0];
        default: ;
      endcase
    end
  end

  // Active configuration: copied only at a line start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_act <= '0;
      sel_act <= '0;
      cat_act <= 1'b0;
    end else if (line_start) begin
      ptr_act <= ptr_shd;
      sel_act <= sel_shd;
      cat_act <= cat_shd;
    end
  end
endmodule

// File: rtl/vcp_out_lane.sv
module vcp_out_lane #(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned N_SLOT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic [CNT_W-1:0] cnt,
  input  logic start_pol,
  input  logic [N_SLOT-1:0][CNT_W-1:0] pos,
  output logic hit,
  output logic level
);
  localparam logic [CNT_W-1:0] UNUSED_POS = '1;

  function automatic logic any_hit(input logic [CNT_W-1:0] c,
                                   input logic [N_SLOT-1:0][CNT_W-1:0] p);
    logic h;
    h = 1'b0;
    for (int k = 0; k < int'(N_SLOT); k++)
      if (p[k] != UNUSED_POS && p[k] == c) h = 1'b1;
    return h;
  endfunction

  assign hit = any_hit(cnt, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level <= 1'b0;
    else if (line_start) level <= start_pol;
    else if (hit)        level <= ~level;
  end
endmodule

// File: rtl/vcp_group_sel.sv
module vcp_group_sel
  import vcp_pkg::*;
#(
  parameter int unsigned N_OUT = 24,
  parameter int unsigned N_GRP = 16,
  parameter int unsigned CNT_W = 13,
  parameter int unsigned N_TOG = 4,
  localparam int unsigned GRP_W  = $clog2(N_GRP),
  localparam int unsigned OUT_W  = $clog2(N_OUT),
  localparam int unsigned SLOT_W = $clog2(N_TOG + 1),
  localparam int unsigned ADDR_W = 1 + GRP_W + OUT_W + SLOT_W,
  localparam int unsigned PSEL_W = $clog2(VCP_N_PTR),
  localparam int unsigned N_SLOT = VCP_N_PTR * N_TOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_OUT-1:0]  vout
);
  logic line_start;
  logic [CNT_W-1:0] cnt;
  logic [N_GRP-1:0][N_OUT-1:0][N_TOG-1:0][CNT_W-1:0] tog_mem;
  logic [N_GRP-1:0][N_OUT-1:0] pol_mem;
  logic [VCP_N_PTR-1:0][GRP_W-1:0] ptr_act, ptr_shd;
  logic [N_OUT-1:0][PSEL_W-1:0] sel_act, sel_shd;
  logic cat_act, cat_shd;
  logic [N_OUT-1:0] hit_vec;
  logic [N_OUT-1:0] start_pol;

  // Pointer that feeds slot k of an output
  function automatic logic [PSEL_W-1:0] slot_ptr(input logic cat,
                                                 input logic [PSEL_W-1:0] sel,
                                                 input int k);
    return cat ? PSEL_W'(k / N_TOG) : sel;
  endfunction

  // Pointer that supplies the start level
  function automatic logic [PSEL_W-1:0] pol_ptr(input logic cat,
                                                input logic [PSEL_W-1:0] sel);
    return cat ? '0 : sel;
  endfunction

  vcp_line_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .line_start(line_start), .cnt(cnt)
  );

  vcp_regbank #(.N_OUT(N_OUT), .N_GRP(N_GRP), .CNT_W(CNT_W), .N_TOG(N_TOG)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_start(line_start), .tog_mem(tog_mem), .pol_mem(pol_mem),
    .ptr_act(ptr_act), .ptr_shd(ptr_shd), .sel_act(sel_act), .sel_shd(sel_shd),
    .cat_act(cat_act), .cat_shd(cat_shd)
  );

  for (genvar o = 0; o < int'(N_OUT); o++) begin : g_lane
    logic [N_SLOT-1:0][CNT_W-1:0] pos;

    always_comb begin
      for (int k = 0; k < int'(N_SLOT); k++) begin
        if (!cat_act && k >= int'(N_TOG))
          pos[k] = '1;
        else
          pos[k] = tog_mem[ptr_act[slot_ptr(cat_act, sel_act[o], k)]][o][k % N_TOG];
      end
    end

    // Level loaded at line start uses the configuration being made active
    assign start_pol[o] = pol_mem[ptr_shd[pol_ptr(cat_shd, sel_shd[o])]][o];

    vcp_out_lane #(.CNT_W(CNT_W), .N_SLOT(N_SLOT)) lane_i (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .cnt(cnt),
      .start_pol(start_pol[o]), .pos(pos), .hit(hit_vec[o]), .level(vout[o])
    );
  end
endmodule

// File: rtl/vcp_group_sel_chk.sv
module vcp_group_sel_chk #(
  parameter int unsigned N_OUT = 24,
  parameter int unsigned N_GRP = 16,
  parameter int unsigned CNT_W = 13,
  localparam int unsigned GRP_W = $clog2(N_GRP)
) (
  input logic clk,
  input logic rst_n,
  input logic line_start,
  input logic [CNT_W-1:0] cnt,
  input logic [N_OUT-1:0] hit_vec,
  input logic [N_OUT-1:0] vout,
  input logic [3:0][GRP_W-1:0] ptr_act,
  input logic [N_OUT-1:0][1:0] sel_act,
  input logic cat_act
);
  localparam logic [CNT_W-1:0] PARK = '1;

  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> cnt == '0);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && cnt != PARK) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_count_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && cnt == PARK) |=> cnt == PARK);

  p_hold_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && hit_vec == '0) |=> $stable(vout));

  p_unused_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == PARK) |-> hit_vec == '0);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable({cat_act, ptr_act, sel_act}));
endmodule

bind vcp_group_sel vcp_group_sel_chk #(.N_OUT(N_OUT), .N_GRP(N_GRP), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .cnt(cnt),
  .hit_vec(hit_vec), .vout(vout), .ptr_act(ptr_act), .sel_act(sel_act),
  .cat_act(cat_act)
);

// File: tb/vcp_group_sel_tb.sv
`timescale 1ns/1ps
module vcp_group_sel_tb_top;
  localparam int NO = 24;
  localparam int NG = 16;
  localparam int UNUSED = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0;
  logic wr_en = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [NO-1:0] vout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  int m_tog [NG][NO][4];
  bit m_pol [NG][NO];
  int ptr_a [4], ptr_s [4];
  int sel_a [NO], sel_s [NO];
  bit cat_a, cat_s;

  always #4 clk = ~clk;

  vcp_group_sel dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vout(vout)
  );

  function automatic logic [12:0] pat_addr(int g, int o, int s);
    return {1'b0, 4'(g), 5'(o), 3'(s)};
  endfunction

  function automatic logic [12:0] cfg_addr(int kind, int idx);
    return {1'b1, 4'b0, 3'(kind), 5'(idx)};
  endfunction

  function automatic void model_wr(logic [12:0] a, logic [12:0] d);
    int g, o, s, kind, idx;
    if (a[12]) begin
      kind = int'(a[7:5]); idx = int'(a[4:0]);
      if (kind == 0) ptr_s[idx % 4] = int'(d[3:0]);
      else if (kind == 1 && idx < NO) sel_s[idx] = int'(d[1:0]);
      else if (kind == 2) cat_s = d[0];
    end else begin
      g = int'(a[11:8]); o = int'(a[7:3]); s = int'(a[2:0]);
      if (o < NO) begin
        if (s < 4) m_tog[g][o][s] = int'(d);
        else if (s == 4) m_pol[g][o] = d[0];
      end
    end
  endfunction

  // expected level of output o when the counter shows c
  function automatic bit exp_bit(int o, int c);
    int pos [16];
    int n;
    bit lvl, h;
    if (cat_a) begin
      n = 16;
      for (int k = 0; k < 16; k++) pos[k] = m_tog[ptr_a[k / 4]][o][k % 4];
      lvl = m_pol[ptr_a[0]][o];
    end else begin
      n = 4;
      for (int k = 0; k < 4; k++) pos[k] = m_tog[ptr_a[sel_a[o]]][o][k];
      lvl = m_pol[ptr_a[sel_a[o]]][o];
    end
    for (int t = 0; t < c; t++) begin
      h = 1'b0;
      for (int k = 0; k < n; k++) if (pos[k] == t && pos[k] != UNUSED) h = 1'b1;
      if (h) lvl = ~lvl;
    end
    return lvl;
  endfunction

  function automatic logic [NO-1:0] exp_vec(int c);
    logic [NO-1:0] v;
    for (int o = 0; o < NO; o++) v[o] = exp_bit(o, c);
    return v;
  endfunction

  task automatic chk(logic [NO-1:0] got, logic [NO-1:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: vout=%h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [12:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one line: start, then compare every cycle; optional mid-line write
  task automatic run_line(int len, int hold, int mid_at,
                          logic [12:0] ma, logic [12:0] md, string tag);
    @(negedge clk);
    hsync = 1'b1;
    @(posedge clk);
    ptr_a = ptr_s; sel_a = sel_s; cat_a = cat_s;
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      if (k >= hold) hsync = 1'b0;
      if (k == mid_at) begin
        wr_en = 1'b1; wr_addr = ma; wr_data = md; model_wr(ma, md);
      end else wr_en = 1'b0;
      chk(vout, exp_vec(k), tag);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    for (int g = 0; g < NG; g++)
      for (int o = 0; o < NO; o++) begin
        m_pol[g][o] = 1'b0;
        for (int s = 0; s < 4; s++) m_tog[g][o][s] = UNUSED;
      end
    ptr_a = '{default: 0}; ptr_s = '{default: 0};
    sel_a = '{default: 0}; sel_s = '{default: 0};
    cat_a = 1'b0; cat_s = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, nothing moves before the first line
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(vout, '0, "R1 idle after reset");
    end
    run_line(20, 0, -1, '0, '0, "R1 empty bank line");

    // fill the bank with random patterns
    for (int g = 0; g < NG; g++)
      for (int o = 0; o < NO; o++) begin
        for (int s = 0; s < 4; s++)
          wr(pat_addr(g, o, s), ($urandom % 6 == 0) ? 13'(UNUSED) : 13'($urandom % 64));
        wr(pat_addr(g, o, 4), 13'($urandom % 2));
      end

    run_line(70, 0, -1, '0, '0, "R2 default pointer A line");

    // R3/R4: distinct pointers, each output on its own select
    wr(cfg_addr(0, 0), 13'd3); wr(cfg_addr(0, 1), 13'd7);
    wr(cfg_addr(0, 2), 13'd9); wr(cfg_addr(0, 3), 13'd12);
    for (int o = 0; o < NO; o++) wr(cfg_addr(1, o), 13'(o % 4));
    run_line(70, 0, -1, '0, '0, "R3 R4 per-output select");

    // R5: duplicates and an unused slot; R10 ignored slot and output
    wr(pat_addr(5, 0, 0), 13'd10); wr(pat_addr(5, 0, 1), 13'd10);
    wr(pat_addr(5, 0, 2), 13'd20); wr(pat_addr(5, 0, 3), 13'(UNUSED));
    wr(pat_addr(5, 0, 4), 13'd1);
    for (int s = 0; s < 4; s++) wr(pat_addr(5, 1, s), 13'(UNUSED));
    wr(pat_addr(5, 1, 4), 13'd1);
    wr(pat_addr(5, 0, 6), 13'd3);
    wr(pat_addr(5, 27, 0), 13'd2);
    wr(cfg_addr(0, 0), 13'd5);
    for (int o = 0; o < NO; o++) wr(cfg_addr(1, o), 13'd0);
    run_line(70, 0, -1, '0, '0, "R5 R10 slots and ignored addresses");

    // R6: chained mode over four groups
    wr(cfg_addr(0, 0), 13'd1); wr(cfg_addr(0, 1), 13'd4);
    wr(cfg_addr(0, 2), 13'd8); wr(cfg_addr(0, 3), 13'd14);
    wr(cfg_addr(2, 0), 13'd1);
    run_line(70, 0, -1, '0, '0, "R6 chained four groups");

    // R7: B, C, D on one group
    wr(cfg_addr(0, 0), 13'd2); wr(cfg_addr(0, 1), 13'd6);
    wr(cfg_addr(0, 2), 13'd6); wr(cfg_addr(0, 3), 13'd6);
    run_line(70, 0, -1, '0, '0, "R7 chained two distinct groups");

    // R8: config write mid-line has no effect until next line
    wr(cfg_addr(2, 0), 13'd0);
    run_line(70, 0, 5, cfg_addr(0, 0), 13'd11, "R8 pointer write mid-line");
    run_line(70, 0, 8, cfg_addr(2, 0), 13'd1, "R8 new pointer at next line");
    run_line(70, 0, -1, '0, '0, "R8 chained bit applied at next line");

    // R9: hsync held high gives one line start only
    run_line(70, 6, -1, '0, '0, "R9 held sync single start");

    // random mix
    for (int n = 0; n < 6; n++) begin
      for (int p = 0; p < 4; p++) wr(cfg_addr(0, p), 13'($urandom % 16));
      for (int o = 0; o < NO; o++) wr(cfg_addr(1, o), 13'($urandom % 4));
      wr(cfg_addr(2, 0), 13'($urandom % 2));
      run_line(70, 0, -1, '0, '0, "R3 R6 random config");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule